// File: doc/BRIEF.md
# Eight-Operand Compressor-Tree Adder

This block sums eight unsigned operands of `OPW` bits each and presents the total one clock later. It has no tree of full-adder rows. Each bit position of the total gets its own 8:2 compressor column, and that column is built from a hierarchy of smaller 3:2, 4:2, 5:2 and 7:2 cells. Every column reduces its eight operand bits, together with five lateral carries from the column below, to one sum bit, one carry bit and five lateral carries for the column above.

A final recombination adder then folds each column's carry into the sum of the next column up to form the total. The result is `OPW + 3` bits wide, so the largest possible total (eight operands at their maximum value) fits without wrapping.

The operands enter as one flat vector. The adder core is purely combinational. A single output register, loaded when `in_vld` is high, holds the result, and an output valid flag follows `in_vld` by one cycle.

Top module: `oct_add_c82`

## Requirements
- R1: One clock edge after a cycle with `in_vld` high, `sum_o` equals the unsigned sum of the eight operands, where operand k occupies bits `[k*OPW +: OPW]` of `ops_i`.
- R2: `out_vld` equals the value `in_vld` had at the previous clock edge. While `in_vld` is low, `sum_o` keeps its previous value whatever `ops_i` does.
- R3: While `rst` is high at a clock edge, `sum_o` becomes 0 and `out_vld` becomes 0, regardless of `in_vld` and `ops_i`.
- R4: With every operand at its maximum value (0xFF for OPW=8), `sum_o` is 8*(2^OPW-1) = 2040 with no wrap, and no valid result ever exceeds that bound.
- R5: Every compressor cell and every 8:2 column conserves weighted value: the count of its ones at the inputs (operand bits plus carry-ins) equals Sum + 2*(Carry + number of lateral carry-outs set).
- R6: The recombination adder forms result bit n+1 from the Carry of column n added to the Sum of column n+1, with bit 0 equal to the Sum of column 0.
- R7: Columns at positions OPW and above take no operand bits. The lateral carry-outs of the topmost column and its Carry are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operands on `ops_i` are to be summed this cycle |
| ops_i | input | 8*OPW | Eight unsigned operands, operand k at bits [k*OPW +: OPW] |
| out_vld | output | 1 | `sum_o` carries a fresh total |
| sum_o | output | OPW+3 | Registered total of the eight operands |

## Verification
On every cycle, assertions check the following:
- value conservation inside each 3:2, 4:2, 5:2, 7:2 and 8:2 cell;
- the agreement of the recombination chain with the column outputs;
- the silence of the topmost column;
- the hold and valid timing at the register;
- the range bound on the result.

What only the bench's scenarios can show is the following:
- that operand lanes are taken from the right bit positions;
- that carries propagate correctly through patterns that load single columns or all columns at once (a single nonzero operand, walking bits, all 0x80, all 0x7F, alternating bytes, all ones);
- that the register ignores operand changes while idle;
- that reset clears a previously nonzero total.

// File: rtl/mop_pkg.sv
`timescale 1ns/1ps
package mop_pkg;
  // Number of operands summed by one 8:2 column.
  localparam int NOPS = 8;
  // Lateral carries passed from one column to the next.
  localparam int NLAT = 5;

  typedef logic [NLAT-1:0] lat_t;
  typedef logic [NOPS-1:0] colbits_t;

  // Result width needed for NOPS operands of w bits.
  function automatic int total_width(int w);
    return w + $clog2(NOPS);
  endfunction
endpackage

// File: rtl/mop_c32.sv
`timescale 1ns/1ps
// 3:2 cell: a + b + c = s + 2*cy. Written in mux form so it doubles as a full adder.
module mop_c32 (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic s,
  output logic cy
);
  logic p;

  always_comb begin
    p  = a ^ b;
    s  = p ^ c;
    cy = p ? c : a;
  end

  always_comb begin
    if (!$isunknown({a, b, c})) begin
      a_r5_c32_value: assert ({cy, s} == 2'(a) + 2'(b) + 2'(c));
    end
  end
endmodule

// File: rtl/mop_c42.sv
`timescale 1ns/1ps
// 4:2 cell. co is taken from a, b, c only, so it never waits on ci.
module mop_c42 (
  input  logic a,
  input  logic b,
  input  logic c,
  input  logic d,
  input  logic ci,
  output logic s,
  output logic cy,
  output logic co
);
  logic t;

  mop_c32 u_lo (.a(a), .b(b), .c(c),  .s(t), .cy(co));
  mop_c32 u_hi (.a(t), .b(d), .c(ci), .s(s), .cy(cy));

  always_comb begin
    if (!$isunknown({a, b, c, d, ci})) begin
      a_r5_c42_value: assert (3'(a) + 3'(b) + 3'(c) + 3'(d) + 3'(ci)
                              == 3'(s) + {1'b0, cy, 1'b0} + {1'b0, co, 1'b0});
    end
  end
endmodule

// File: rtl/mop_c52.sv
`timescale 1ns/1ps
// 5:2 cell built from a 4:2 cell and a 3:2 cell.
module mop_c52 (
  input  logic [4:0] d,
  input  logic [1:0] ci,
  output logic       s,
  output logic       cy,
  output logic [1:0] co
);
  logic s4;
  logic cy4;
  logic co4;

  mop_c42 u_c42 (
    .a(d[0]), .b(d[1]), .c(d[2]), .d(d[3]), .ci(ci[0]),
    .s(s4), .cy(cy4), .co(co4)
  );
  mop_c32 u_fin (.a(s4), .b(d[4]), .c(ci[1]), .s(s), .cy(cy));

  assign co = {cy4, co4};

  always_comb begin
    if (!$isunknown({d, ci})) begin
      a_r5_c52_value: assert (3'($countones(d)) + 3'($countones(ci))
                              == 3'(s) + 3'({cy, 1'b0}) + 3'({co[0], 1'b0})
                                 + 3'({co[1], 1'b0}));
    end
  end
endmodule

// File: rtl/mop_c72.sv
`timescale 1ns/1ps
// 7:2 cell: two 3:2 cells feed their carries sideways, and a third 3:2 cell merges the sums.
module mop_c72 (
  input  logic [6:0] d,
  output logic       s,
  output logic       cy,
  output logic [1:0] co
);
  logic s_a;
  logic s_b;

  mop_c32 u_a   (.a(d[0]), .b(d[1]), .c(d[2]), .s(s_a), .cy(co[0]));
  mop_c32 u_b   (.a(d[3]), .b(d[4]), .c(d[5]), .s(s_b), .cy(co[1]));
  mop_c32 u_fin (.a(s_a),  .b(s_b),  .c(d[6]), .s(s),   .cy(cy));

  always_comb begin
    if (!$isunknown(d)) begin
      a_r5_c72_value: assert (3'($countones(d))
                              == 3'(s) + 3'({cy, 1'b0}) + 3'({co[0], 1'b0})
                                 + 3'({co[1], 1'b0}));
    end
  end
endmodule

// File: rtl/mop_c82.sv
`timescale 1ns/1ps
// 8:2 column: a 7:2 cell takes seven operand bits, and a 5:2 cell takes its sum,
// the eighth operand bit and the five carry-ins.
module mop_c82
  import mop_pkg::*;
(
  input  colbits_t d,
  input  lat_t     ci,
  output logic     s,
  output logic     cy,
  output lat_t     co
);
  logic       s7;
  logic       cy7;
  logic [1:0] co7;
  logic [1:0] co5;

  mop_c72 u_c72 (.d(d[6:0]), .s(s7), .cy(cy7), .co(co7));

  mop_c52 u_c52 (
    .d ({ci[2], ci[1], ci[0], d[7], s7}),
    .ci({ci[4], ci[3]}),
    .s (s),
    .cy(cy),
    .co(co5)
  );

  assign co = {co5, cy7, co7};

  always_comb begin
    if (!$isunknown({d, ci})) begin
      a_r5_c82_value: assert (4'($countones(d)) + 4'($countones(ci))
                              == 4'(s) + 4'({cy, 1'b0}) + 4'({$countones(co), 1'b0}));
    end
  end
endmodule

// File: rtl/mop_cols.sv
`timescale 1ns/1ps
// One 8:2 column per result bit. Lateral carries climb from column n to column n+1.
module mop_cols
  import mop_pkg::*;
#(
  parameter int OPW   = 8,
  parameter int OUT_W = total_width(OPW)
) (
  input  logic [NOPS*OPW-1:0] ops,
  output logic [OUT_W-1:0]    s_vec,
  output logic [OUT_W-1:0]    cy_vec,
  output lat_t                top_co
);
  for (genvar n = 0; n < OUT_W; n++) begin : g_col
    colbits_t dbits;
    lat_t     cin;
    lat_t     co;

    if (n < OPW) begin : g_data
      always_comb begin
        for (int k = 0; k < NOPS; k++) dbits[k] = ops[k*OPW + n];
      end
    end else begin : g_empty
      assign dbits = '0;
    end

    if (n == 0) begin : g_first
      assign cin = '0;
    end else begin : g_chain
      assign cin = g_col[n-1].co;
    end

    mop_c82 u_col (.d(dbits), .ci(cin), .s(s_vec[n]), .cy(cy_vec[n]), .co(co));
  end

  assign top_co = g_col[OUT_W-1].co;
endmodule

// File: rtl/mop_recomb.sv
`timescale 1ns/1ps
// Recombination adder: column n's carry joins column n+1's sum.
// A ripple chain of 3:2 cells used as full adders.
module mop_recomb #(
  parameter int W = 11
) (
  input  logic [W-1:0] s,
  input  logic [W-1:0] cy,
  output logic [W-1:0] r
);
  logic [W-1:0] b_w;
  logic [W:0]   rc;

  assign b_w   = {cy[W-2:0], 1'b0};
  assign rc[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    mop_c32 u_fa (.a(s[i]), .b(b_w[i]), .c(rc[i]), .s(r[i]), .cy(rc[i+1]));
  end

  always_comb begin
    if (!$isunknown({s, cy})) begin
      a_r6_recomb_value: assert (r == s + {cy[W-2:0], 1'b0});
      a_r7_no_top_spill: assert (cy[W-1] == 1'b0 && rc[W] == 1'b0);
    end
  end
endmodule

// File: rtl/oct_add_c82.sv
`timescale 1ns/1ps
module oct_add_c82
  import mop_pkg::*;
#(
  parameter int OPW = 8,
  localparam int OUT_W = total_width(OPW)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_vld,
  input  logic [NOPS*OPW-1:0] ops_i,
  output logic                out_vld,
  output logic [OUT_W-1:0]    sum_o
);
  localparam int MAXSUM = NOPS * ((1 << OPW) - 1);

  logic [OUT_W-1:0] s_vec;
  logic [OUT_W-1:0] cy_vec;
  lat_t             top_co;
  logic [OUT_W-1:0] sum_d;

  mop_cols #(.OPW(OPW), .OUT_W(OUT_W)) u_cols (
    .ops   (ops_i),
    .s_vec (s_vec),
    .cy_vec(cy_vec),
    .top_co(top_co)
  );

  mop_recomb #(.W(OUT_W)) u_recomb (.s(s_vec), .cy(cy_vec), .r(sum_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      sum_o   <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) sum_o <= sum_d;
    end
  end

  // Behavioural reference, used only by the assertions below.
  logic [OUT_W-1:0] ref_d;
  always_comb begin
    ref_d = '0;
    for (int k = 0; k < NOPS; k++) ref_d = ref_d + OUT_W'(ops_i[k*OPW +: OPW]);
  end

  a_r1_sum_match: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> sum_o == $past(ref_d));
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(sum_o));
  a_r2_vld_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_vld == $past(in_vld));
  a_r3_reset_clear: assert property (@(posedge clk)
    rst |=> (sum_o == '0 && !out_vld));
  a_r4_range: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> int'(sum_o) <= MAXSUM);
  a_r7_top_silent: assert property (@(posedge clk) disable iff (rst)
    top_co == '0 && cy_vec[OUT_W-1] == 1'b0);
endmodule

// File: tb/oct_add_c82_tb_top.sv
`timescale 1ns/1ps
module oct_add_c82_tb_top;
  import mop_pkg::*;

  localparam int OPW   = 8;
  localparam int OUT_W = OPW + $clog2(NOPS);
  localparam int MAXOP = (1 << OPW) - 1;

  logic                clk    = 1'b0;
  logic                rst    = 1'b1;
  logic                in_vld = 1'b0;
  logic [NOPS*OPW-1:0] ops    = '0;
  logic                out_vld;
  logic [OUT_W-1:0]    sum_o;

  int    checks = 0;
  int    fails  = 0;
  int    exp_q[$];
  string tag_q[$];
  bit    done = 1'b0;

  oct_add_c82 #(.OPW(OPW)) dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .ops_i(ops),
    .out_vld(out_vld), .sum_o(sum_o)
  );

  always #2.5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_sum(logic [NOPS*OPW-1:0] v);
    int acc = 0;
    for (int k = 0; k < NOPS; k++) acc += int'(v[k*OPW +: OPW]);
    return acc;
  endfunction

  function automatic logic [NOPS*OPW-1:0] fill(logic [OPW-1:0] b);
    logic [NOPS*OPW-1:0] v;
    for (int k = 0; k < NOPS; k++) v[k*OPW +: OPW] = b;
    return v;
  endfunction

  // Driver: applies operands and pushes the expected total into the scoreboard.
  task automatic drive(logic [NOPS*OPW-1:0] v, string tag);
    @(negedge clk);
    ops    = v;
    in_vld = 1'b1;
    exp_q.push_back(ref_sum(v));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
    end
  endtask

  // Monitor: pops and compares whenever the design flags a result.
  always @(negedge clk) begin
    if (!rst && out_vld) begin
      if (exp_q.size() == 0) chk("R2 spurious out_vld", 1, 0);
      else chk(tag_q.pop_front(), int'(sum_o), exp_q.pop_front());
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [NOPS*OPW-1:0] v;
    logic [NOPS*OPW-1:0] held;

    // R3: reset dominates an active request carrying nonzero operands.
    ops    = fill(OPW'(MAXOP));
    in_vld = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 sum_o under reset", int'(sum_o), 0);
    chk("R3 out_vld under reset", int'(out_vld), 0);
    rst    = 1'b0;
    in_vld = 1'b0;
    ops    = '0;
    idle(1);

    // R1: zeros, then lane positions by distinct operand values.
    drive('0, "R1 all zero");
    for (int k = 0; k < NOPS; k++) v[k*OPW +: OPW] = OPW'(k + 1);
    drive(v, "R1 lane order");
    // R4: every operand at its maximum.
    drive(fill(OPW'(MAXOP)), "R4 all max");
    // R5: a single nonzero operand in each lane.
    for (int k = 0; k < NOPS; k++) begin
      v = '0;
      v[k*OPW +: OPW] = OPW'(MAXOP);
      drive(v, "R5 single operand");
    end
    // R5: a walking bit loads one column at a time.
    for (int n = 0; n < OPW; n++) drive(fill(OPW'(1 << n)), "R5 walking column");
    // R6: carries out of every column, and alternating patterns.
    drive(fill(OPW'(MAXOP >> 1)), "R6 all 0x7F");
    for (int k = 0; k < NOPS; k++) v[k*OPW +: OPW] = (k % 2 == 0) ? 8'hAA : 8'h55;
    drive(v, "R6 alternating");
    // R7: only the top operand column is loaded.
    drive(fill(OPW'(1 << (OPW - 1))), "R7 top column full");

    // R1: random traffic, back to back.
    for (int i = 0; i < 300; i++) begin
      for (int k = 0; k < NOPS; k++) v[k*OPW +: OPW] = OPW'($urandom);
      drive(v, "R1 random");
    end

    // R2: while idle the total holds even though the operands change.
    held = fill(8'h3C);
    drive(held, "R2 before hold");
    @(negedge clk);
    in_vld = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      for (int k = 0; k < NOPS; k++) ops[k*OPW +: OPW] = OPW'($urandom);
      chk("R2 sum_o held while idle", int'(sum_o), ref_sum(held));
      chk("R2 out_vld low while idle", int'(out_vld), 0);
    end

    // R3: reset clears a nonzero total.
    idle(2);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 sum_o cleared", int'(sum_o), 0);
    chk("R3 out_vld cleared", int'(out_vld), 0);
    rst = 1'b0;
    idle(2);

    chk("R1 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule